// File: doc/BRIEF.md
# Soft-Start and Fault Drive Gating Stage

This block sits between the PWM generators of a three-channel digital power controller and the output drivers. Every drive signal passes through it and can be forced low. Each of the four synchronous-rectifier (SR) drives is assigned to one channel. An SR drive can be held off while its own channel is ramping through soft start. A fault flag shuts down all drives, either in the same cycle or at the next end-of-PWM-cycle strobe, as a configuration input selects. The block also produces two masking signals: a blanking enable for volt-second balance control during the balance channel's soft start, and a masked copy of the current-sense flag that is suppressed during the flag re-enable interval.

All gating is combinational logic fed by the live inputs and by the registered shutdown state. A gated drive therefore cannot pulse high while its force-off condition holds. The shutdown state is sticky. It is left only through the synchronous clear input or the reset.

Top module: `drive_gate`

## Requirements
- R1: After reset, `shut_pending` and `shut_active` are 0. With no soft start and no fault, every drive output equals its input.
- R2: Each SR drive i has a 2-bit channel code at `sr_assign[2i+1:2i]`: 0 means A, 1 means B and 2 means C. If channel c is in soft start and `cfg_sr_off_en[c]` is 1, every SR drive assigned to c is low, whatever `sr_pwm_dis` holds.
- R3: If `cfg_sr_off_en[c]` is 0, an SR drive assigned to c is low during c's soft start only when its own `sr_pwm_dis` bit is 1. A soft start of any other channel has no effect on it.
- R4: With `cfg_shut_now` = 1, a cycle with `fault_in` = 1 drives all outputs low in that same cycle, and `shut_active` is 1 from the next cycle.
- R5: With `cfg_shut_now` = 0, a fault sets `shut_pending` in the next cycle while the drives keep passing. The drives go low in the cycle where `cycle_end` is 1, and `shut_active` is 1 from the cycle after that.
- R6: `shut_active` holds, with all drives low, until `shut_clr` is 1. One cycle later the state is idle and the drives pass again.
- R7: Further faults while `shut_pending` is 1 do not restart the wait. The first `cycle_end` strobe completes the shutdown.
- R8: In deferred mode, a fault that arrives in the same cycle as `cycle_end` drives the outputs low in that cycle, and `shut_active` is 1 from the next.
- R9: `bal_blank` is `cfg_bal_blank_en` AND the soft-start status of channel A (when `cfg_bal_sel_c` = 0) or of channel C (when `cfg_bal_sel_c` = 1).
- R10: `cs_flag_out` is `cs_flag_in`, forced to 0 while both `cfg_cs_blank_en` and `reenable_win` are 1.
- R11: An SR drive with channel code 3 is never forced off by soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shut_clr | input | 1 | Synchronous release of the shutdown state |
| fault_in | input | 1 | Fault flag from the detection logic |
| cycle_end | input | 1 | One-cycle strobe at the end of each PWM period |
| cfg_shut_now | input | 1 | 1: fault stops the drives at once; 0: at the cycle end |
| cfg_sr_off_en | input | 3 | Per-channel SR force-off enable during soft start |
| cfg_bal_blank_en | input | 1 | Enable for blanking balance control during soft start |
| cfg_bal_sel_c | input | 1 | Balance channel: 0 selects A, 1 selects C |
| cfg_cs_blank_en | input | 1 | Enable for masking the current-sense flag |
| sr_assign | input | 8 | Channel code of each SR drive, 2 bits each |
| sr_pwm_dis | input | 4 | Per-SR-drive disable during its channel's soft start |
| ss_active | input | 3 | Soft-start status of channels A, B and C |
| reenable_win | input | 1 | Flag re-enable interval is active |
| cs_flag_in | input | 1 | Raw current-sense flag |
| pwm_main_in | input | 4 | Raw main drive signals |
| sr_in | input | 4 | Raw SR drive signals |
| pwm_main_out | output | 4 | Gated main drives |
| sr_out | output | 4 | Gated SR drives |
| shut_pending | output | 1 | Deferred shutdown is waiting for the cycle end |
| shut_active | output | 1 | Drives are held low by shutdown |
| bal_blank | output | 1 | Volt-second balance control is blanked |
| cs_flag_out | output | 1 | Current-sense flag after masking |

## Verification
Reaching the pending state takes a deferred-mode fault. Holding it open across several repeated faults takes extra stimulus: the bench keeps `cycle_end` low while it pulses `fault_in` again, then releases a single strobe. A restarted wait or a missed strobe would show up either as drives that stay high after the strobe or as drives that go low too early. The coincidence of a fault with the strobe in the same cycle is created by driving both inputs in one cycle from the idle state. The bench then checks the combinational output in that cycle and the registered state in the next.

// File: rtl/dg_pkg.sv
package dg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SHUT = 2'd2
  } shut_st_e;
endpackage

// File: rtl/dg_shutdown_fsm.sv
module dg_shutdown_fsm
  import dg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic fault,
  input  logic now_mode,
  input  logic cycle_end,
  output logic kill,
  output logic pending,
  output logic active
);
  shut_st_e st_q, st_d;
  logic     wait_end;

  // a deferred request exists if already pending or newly raised from idle
  assign wait_end = (st_q == ST_PEND) || ((st_q == ST_IDLE) && fault && !now_mode);

  always_comb begin
    st_d = st_q;
    if (clr) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (fault && now_mode)      st_d = ST_SHUT;
          else if (fault && cycle_end) st_d = ST_SHUT;
          else if (fault)              st_d = ST_PEND;
        end
        ST_PEND: begin
          if (cycle_end || (fault && now_mode)) st_d = ST_SHUT;
        end
        ST_SHUT: st_d = ST_SHUT;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign kill    = (st_q == ST_SHUT) || (fault && now_mode) || (wait_end && cycle_end);
  assign pending = (st_q == ST_PEND);
  assign active  = (st_q == ST_SHUT);
endmodule

// File: rtl/dg_sr_mask.sv
module dg_sr_mask #(
  parameter int NCH = 3,
  parameter int NSR = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0]     ss_active,
  input  logic [NCH-1:0]     off_en,
  input  logic [NSR*CHW-1:0] assign_code,
  input  logic [NSR-1:0]     pwm_dis,
  output logic [NSR-1:0]     force_off
);
  for (genvar i = 0; i < NSR; i++) begin : g_out
    logic [CHW-1:0] code;
    assign code = assign_code[i*CHW +: CHW];
    always_comb begin
      force_off[i] = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (code == CHW'(c))
          force_off[i] = ss_active[c] && (off_en[c] || pwm_dis[i]);
      end
    end
  end
endmodule

// File: rtl/dg_blanking.sv
module dg_blanking #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] ss_active,
  input  logic           bal_en,
  input  logic           bal_sel_last,
  input  logic           cs_en,
  input  logic           reenable_win,
  input  logic           cs_flag_in,
  output logic           bal_blank,
  output logic           cs_flag_out
);
  localparam int LAST = NCH - 1;
  logic bal_ss;

  assign bal_ss      = bal_sel_last ? ss_active[LAST] : ss_active[0];
  assign bal_blank   = bal_en && bal_ss;
  assign cs_flag_out = cs_flag_in && !(cs_en && reenable_win);
endmodule

// File: rtl/drive_gate.sv
module drive_gate #(
  parameter int NCH   = 3,
  parameter int NSR   = 4,
  parameter int NMAIN = 4,
  parameter int CHW   = $clog2(NCH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shut_clr,
  input  logic               fault_in,
  input  logic               cycle_end,
  input  logic               cfg_shut_now,
  input  logic [NCH-1:0]     cfg_sr_off_en,
  input  logic               cfg_bal_blank_en,
  input  logic               cfg_bal_sel_c,
  input  logic               cfg_cs_blank_en,
  input  logic [NSR*CHW-1:0] sr_assign,
  input  logic [NSR-1:0]     sr_pwm_dis,
  input  logic [NCH-1:0]     ss_active,
  input  logic               reenable_win,
  input  logic               cs_flag_in,
  input  logic [NMAIN-1:0]   pwm_main_in,
  input  logic [NSR-1:0]     sr_in,
  output logic [NMAIN-1:0]   pwm_main_out,
  output logic [NSR-1:0]     sr_out,
  output logic               shut_pending,
  output logic               shut_active,
  output logic               bal_blank,
  output logic               cs_flag_out
);
  logic           kill;
  logic [NSR-1:0] sr_force;

  dg_shutdown_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .clr       (shut_clr),
    .fault     (fault_in),
    .now_mode  (cfg_shut_now),
    .cycle_end (cycle_end),
    .kill      (kill),
    .pending   (shut_pending),
    .active    (shut_active)
  );

  dg_sr_mask #(.NCH(NCH), .NSR(NSR), .CHW(CHW)) u_mask (
    .ss_active   (ss_active),
    .off_en      (cfg_sr_off_en),
    .assign_code (sr_assign),
    .pwm_dis     (sr_pwm_dis),
    .force_off   (sr_force)
  );

  dg_blanking #(.NCH(NCH)) u_blank (
    .ss_active    (ss_active),
    .bal_en       (cfg_bal_blank_en),
    .bal_sel_last (cfg_bal_sel_c),
    .cs_en        (cfg_cs_blank_en),
    .reenable_win (reenable_win),
    .cs_flag_in   (cs_flag_in),
    .bal_blank    (bal_blank),
    .cs_flag_out  (cs_flag_out)
  );

  for (genvar m = 0; m < NMAIN; m++) begin : g_main
    assign pwm_main_out[m] = pwm_main_in[m] && !kill;
  end

  for (genvar s = 0; s < NSR; s++) begin : g_sr
    assign sr_out[s] = sr_in[s] && !kill && !sr_force[s];
  end
endmodule

// File: rtl/dg_checker.sv
module dg_checker #(
  parameter int NCH   = 3,
  parameter int NSR   = 4,
  parameter int NMAIN = 4,
  parameter int CHW   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               shut_clr,
  input logic               fault_in,
  input logic               cycle_end,
  input logic               cfg_shut_now,
  input logic [NCH-1:0]     cfg_sr_off_en,
  input logic               cfg_bal_blank_en,
  input logic               cfg_cs_blank_en,
  input logic [NSR*CHW-1:0] sr_assign,
  input logic [NSR-1:0]     sr_pwm_dis,
  input logic [NCH-1:0]     ss_active,
  input logic               reenable_win,
  input logic [NMAIN-1:0]   pwm_main_in,
  input logic [NSR-1:0]     sr_in,
  input logic [NMAIN-1:0]   pwm_main_out,
  input logic [NSR-1:0]     sr_out,
  input logic               shut_pending,
  input logic               shut_active,
  input logic               bal_blank,
  input logic               cs_flag_out
);
  AST_IMMEDIATE_KILL: assert property (@(posedge clk) disable iff (rst)
    fault_in && cfg_shut_now |-> (pwm_main_out == '0) && (sr_out == '0)); // R4
  AST_IMMEDIATE_STATE: assert property (@(posedge clk) disable iff (rst)
    fault_in && cfg_shut_now && !shut_clr |=> shut_active); // R4
  AST_PEND_PASSES: assert property (@(posedge clk) disable iff (rst)
    shut_pending && !cycle_end && !(fault_in && cfg_shut_now) |-> pwm_main_out == pwm_main_in); // R5
  AST_PEND_TO_SHUT: assert property (@(posedge clk) disable iff (rst)
    shut_pending && cycle_end && !shut_clr |=> shut_active); // R5
  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (rst)
    shut_active && !shut_clr |=> shut_active); // R6
  AST_SHUT_LOW: assert property (@(posedge clk) disable iff (rst)
    shut_active |-> (pwm_main_out == '0) && (sr_out == '0)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    shut_pending && fault_in && !cycle_end && !shut_clr && !cfg_shut_now |=> shut_pending); // R7
  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shut_pending, shut_active})); // R1
  AST_BAL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    bal_blank |-> cfg_bal_blank_en); // R9
  AST_CS_MASKED: assert property (@(posedge clk) disable iff (rst)
    cfg_cs_blank_en && reenable_win |-> !cs_flag_out); // R10

  for (genvar i = 0; i < NSR; i++) begin : g_sr_chk
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      AST_SR_FORCED: assert property (@(posedge clk) disable iff (rst)
        ss_active[c] && cfg_sr_off_en[c] && (sr_assign[i*CHW +: CHW] == CHW'(c)) |-> !sr_out[i]); // R2
      AST_SR_DIS_ONLY: assert property (@(posedge clk) disable iff (rst)
        ss_active[c] && !cfg_sr_off_en[c] && !sr_pwm_dis[i] && (sr_assign[i*CHW +: CHW] == CHW'(c))
        && !fault_in && !shut_pending && !shut_active |-> sr_out[i] == sr_in[i]); // R3
    end
  end
endmodule

bind drive_gate dg_checker #(.NCH(NCH), .NSR(NSR), .NMAIN(NMAIN), .CHW(CHW)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .shut_clr         (shut_clr),
  .fault_in         (fault_in),
  .cycle_end        (cycle_end),
  .cfg_shut_now     (cfg_shut_now),
  .cfg_sr_off_en    (cfg_sr_off_en),
  .cfg_bal_blank_en (cfg_bal_blank_en),
  .cfg_cs_blank_en  (cfg_cs_blank_en),
  .sr_assign        (sr_assign),
  .sr_pwm_dis       (sr_pwm_dis),
  .ss_active        (ss_active),
  .reenable_win     (reenable_win),
  .pwm_main_in      (pwm_main_in),
  .sr_in            (sr_in),
  .pwm_main_out     (pwm_main_out),
  .sr_out           (sr_out),
  .shut_pending     (shut_pending),
  .shut_active      (shut_active),
  .bal_blank        (bal_blank),
  .cs_flag_out      (cs_flag_out)
);

// File: tb/tb_drive_gate.sv
`timescale 1ns/1ps
module tb_drive_gate;
  logic       clk = 1'b0;
  logic       rst;
  logic       shut_clr, fault_in, cycle_end, cfg_shut_now;
  logic [2:0] cfg_sr_off_en;
  logic       cfg_bal_blank_en, cfg_bal_sel_c, cfg_cs_blank_en;
  logic [7:0] sr_assign;
  logic [3:0] sr_pwm_dis;
  logic [2:0] ss_active;
  logic       reenable_win, cs_flag_in;
  logic [3:0] pwm_main_in, sr_in;
  logic [3:0] pwm_main_out, sr_out;
  logic       shut_pending, shut_active, bal_blank, cs_flag_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  drive_gate dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    shut_clr = 0; fault_in = 0; cycle_end = 0; cfg_shut_now = 0;
    cfg_sr_off_en = 3'b000; cfg_bal_blank_en = 0; cfg_bal_sel_c = 0; cfg_cs_blank_en = 0;
    sr_assign = {2'd2, 2'd1, 2'd0, 2'd0}; sr_pwm_dis = 4'h0; ss_active = 3'b000;
    reenable_win = 0; cs_flag_in = 0; pwm_main_in = 4'hF; sr_in = 4'hF;
  endtask

  task automatic clear_shut();
    step(); shut_clr = 1;
    step(); shut_clr = 0; #1;
  endtask

  task automatic t_reset();
    idle_inputs(); rst = 1;
    step(); step(); rst = 0; #1;
    chk("R1 pending", shut_pending, 0);
    chk("R1 active", shut_active, 0);
    chk("R1 main", pwm_main_out, 4'hF);
    chk("R1 sr", sr_out, 4'hF);
  endtask

  task automatic t_sr_force();
    step(); ss_active = 3'b001; cfg_sr_off_en = 3'b001; #1;
    chk("R2 chA forced", sr_out, 4'b1100);
    step(); ss_active = 3'b100; cfg_sr_off_en = 3'b100; sr_pwm_dis = 4'h0; #1;
    chk("R2 chC forced", sr_out, 4'b0111);
    step(); ss_active = 3'b000; cfg_sr_off_en = 3'b111; #1;
    chk("R2 no soft start", sr_out, 4'hF);
  endtask

  task automatic t_sr_pwmdis();
    step(); ss_active = 3'b010; cfg_sr_off_en = 3'b000; sr_pwm_dis = 4'b0000; #1;
    chk("R3 dis clear passes", sr_out, 4'hF);
    step(); sr_pwm_dis = 4'b0100; #1;
    chk("R3 own dis bit", sr_out, 4'b1011);
    step(); sr_pwm_dis = 4'b0011; #1;
    chk("R3 other channel dis ignored", sr_out, 4'hF);
    step(); ss_active = 3'b000; sr_pwm_dis = 4'h0;
  endtask

  task automatic t_unassigned();
    step(); sr_assign = {2'd3, 2'd3, 2'd0, 2'd3}; ss_active = 3'b111;
    cfg_sr_off_en = 3'b111; sr_pwm_dis = 4'hF; #1;
    chk("R11 code3 never forced", sr_out, 4'b1101);
    step(); idle_inputs(); #1;
  endtask

  task automatic t_immediate();
    step(); cfg_shut_now = 1; fault_in = 1; #1;
    chk("R4 same cycle main", pwm_main_out, 0);
    chk("R4 same cycle sr", sr_out, 0);
    step(); fault_in = 0; #1;
    chk("R4 active next", shut_active, 1);
    step(); step(); #1;
    chk("R6 sticky", {shut_active, pwm_main_out}, {1'b1, 4'h0});
    clear_shut();
    chk("R6 released", {shut_active, shut_pending, pwm_main_out}, {2'b00, 4'hF});
    cfg_shut_now = 0;
  endtask

  task automatic t_deferred();
    step(); fault_in = 1; #1;
    chk("R5 fault cycle passes", pwm_main_out, 4'hF);
    step(); fault_in = 0; #1;
    chk("R5 pending", shut_pending, 1);
    chk("R5 still passing", pwm_main_out, 4'hF);
    for (int k = 0; k < 3; k++) begin
      step(); fault_in = 1; #1;
      chk("R7 refault keeps pending", {shut_pending, pwm_main_out}, {1'b1, 4'hF});
    end
    step(); fault_in = 0; cycle_end = 1; #1;
    chk("R7 first strobe kills", {pwm_main_out, sr_out}, 8'h00);
    step(); cycle_end = 0; #1;
    chk("R5 active after strobe", {shut_active, shut_pending}, 2'b10);
    chk("R5 held low", pwm_main_out, 0);
    clear_shut();
    chk("R6 released deferred", shut_active, 0);
  endtask

  task automatic t_coincide();
    step(); fault_in = 1; cycle_end = 1; #1;
    chk("R8 low same cycle", pwm_main_out, 0);
    step(); fault_in = 0; cycle_end = 0; #1;
    chk("R8 active next", {shut_active, shut_pending}, 2'b10);
    clear_shut();
  endtask

  task automatic t_balance();
    step(); cfg_bal_blank_en = 1; cfg_bal_sel_c = 0; ss_active = 3'b001; #1;
    chk("R9 A selected", bal_blank, 1);
    step(); ss_active = 3'b100; #1;
    chk("R9 C ignored when A selected", bal_blank, 0);
    step(); cfg_bal_sel_c = 1; #1;
    chk("R9 C selected", bal_blank, 1);
    step(); cfg_bal_blank_en = 0; #1;
    chk("R9 disabled", bal_blank, 0);
    step(); ss_active = 0; cfg_bal_sel_c = 0;
  endtask

  task automatic t_cs();
    step(); cs_flag_in = 1; reenable_win = 1; cfg_cs_blank_en = 0; #1;
    chk("R10 no mask when off", cs_flag_out, 1);
    step(); cfg_cs_blank_en = 1; #1;
    chk("R10 masked in window", cs_flag_out, 0);
    step(); reenable_win = 0; #1;
    chk("R10 passes outside window", cs_flag_out, 1);
  endtask

  initial begin
    t_reset();
    t_sr_force();
    t_sr_pwmdis();
    t_unassigned();
    t_immediate();
    t_deferred();
    t_coincide();
    t_balance();
    t_cs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule